// File: doc/BRIEF.md
# Interval Endpoint Arithmetic Unit

This block computes one interval operation per clock on two operand intervals, X = [xl, xu] and Y = [yl, yu]. Each endpoint is a 16-bit two's complement value. The unit returns a lower and an upper result endpoint, each 32 bits wide, so that no arithmetic result is ever lost inside the unit. Every result lane also raises a flag when its value no longer fits the 16-bit operand format. A later scaling stage can use that flag to shift the block and raise its exponent. That stage is not part of this block.

A small classifier examines the signs of the operand endpoints. For a product it picks which endpoint pair each result lane multiplies. It also reports whether the two operand intervals share no point, which marks an intersection result as empty. The only division is a shift by a power of two, so every command gives a defined result. A result appears one cycle after its command is accepted. The outputs hold that result until the next accepted command.

Top module: `ival_alu`

## Requirements
- R1: When `in_valid` is high, the results appear on the outputs after the next rising clock edge, with `out_valid` high for that one cycle. When `in_valid` is low, `out_valid` falls and `zl`, `zu`, `ovf_lo`, `ovf_hi` and `disjoint` keep their last values. While `rst_n` is low, all outputs are zero.
- R2: Command 0 (sum) gives [xl+yl, xu+yu]. Command 1 (difference) gives [xl−yu, xu−yl].
- R3: Command 2 (centre) gives floor((xl+xu)/2) on both lanes. Command 3 (span) gives xu−xl on both lanes.
- R4: Command 4 (hull) gives [min(xl,yl), max(xu,yu)]. Command 5 (overlap) gives [max(xl,yl), min(xu,yu)]. For every accepted command, `disjoint` is high exactly when yu < xl or xu < yl.
- R5: Command 6 gives the lower envelope [min(xl,yl), min(xu,yu)]. Command 7 gives the upper envelope [max(xl,yl), max(xu,yu)].
- R6: Commands 8, 9 and 10 apply bitwise AND, OR and XOR to the 16-bit lower endpoint pair for `zl` and to the upper endpoint pair for `zu`, each result sign-extended to 32 bits.
- R7: Command 11 gives the exact interval product [min, max] over the four endpoint products. This holds for every combination of an all-nonnegative interval, an all-negative interval, and an interval that contains zero with a negative lower end.
- R8: Command 12 divides X by 2^k, where k is yl[3:0]. The lower lane rounds toward minus infinity and the upper lane rounds toward plus infinity.
- R9: Command 13 gives, for each endpoint of X, the count of redundant sign bits. This is the number of bits below the MSB that equal the MSB, from 0 to 15. `zl` is the count for xl and `zu` is the count for xu.
- R10: `ovf_lo` is high exactly when `zl` lies outside [−32768, 32767]. `ovf_hi` is high exactly when `zu` lies outside that range. Each flag depends only on its own lane.
- R11: Commands 14 and 15 give zero on both lanes, with both overflow flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the command and operands this cycle |
| cmd | input | 4 | Command code |
| xl | input | 16 | Lower endpoint of X, signed |
| xu | input | 16 | Upper endpoint of X, signed |
| yl | input | 16 | Lower endpoint of Y, signed; also the shift amount for division |
| yu | input | 16 | Upper endpoint of Y, signed |
| out_valid | output | 1 | A new result is on the outputs |
| zl | output | 32 | Lower result endpoint, signed |
| zu | output | 32 | Upper result endpoint, signed |
| ovf_lo | output | 1 | Lower result exceeds the 16-bit signed range |
| ovf_hi | output | 1 | Upper result exceeds the 16-bit signed range |
| disjoint | output | 1 | The operand intervals have no common point |

## Verification
The product is run with all nine sign-class pairings of X and Y. Each pairing selects a different endpoint pair per lane, so a wrong selection shows up as a wrong bound. The mixed-by-mixed pairing separately checks the min/max choice between two candidate products. Hull and overlap are run with nested, partly overlapping, touching and separated operands, which tells the disjoint comparison apart from a plain ordering test. Division uses odd, negative and exact values at several shift counts, so that the two rounding directions differ. Sums at the edges of the 16-bit range show that each lane raises only its own overflow flag.

// File: rtl/ival_pkg.sv
package ival_pkg;

    typedef enum logic [3:0] {
        OP_SUM  = 4'd0,
        OP_DIFF = 4'd1,
        OP_CTR  = 4'd2,
        OP_SPAN = 4'd3,
        OP_HULL = 4'd4,
        OP_OVLP = 4'd5,
        OP_LENV = 4'd6,
        OP_UENV = 4'd7,
        OP_BAND = 4'd8,
        OP_BOR  = 4'd9,
        OP_BXOR = 4'd10,
        OP_MUL  = 4'd11,
        OP_SHR  = 4'd12,
        OP_LSB  = 4'd13
    } ival_op_e;

    typedef enum logic [1:0] {
        SC_NONNEG = 2'd0,
        SC_NEG    = 2'd1,
        SC_STRAD  = 2'd2
    } sign_cls_e;

    // For each lane: which X endpoint (a_up) and which Y endpoint (b_up)
    // feed the primary product; strad2 requests the secondary product.
    typedef struct packed {
        logic lo_a_up;
        logic lo_b_up;
        logic hi_a_up;
        logic hi_b_up;
        logic strad2;
    } mul_pick_t;

endpackage

// File: rtl/ival_flag_gen.sv
module ival_flag_gen
    import ival_pkg::*;
#(
    parameter int W = 16
) (
    input  logic signed [W-1:0] xl,
    input  logic signed [W-1:0] xu,
    input  logic signed [W-1:0] yl,
    input  logic signed [W-1:0] yu,
    output mul_pick_t           pick,
    output logic                disjoint
);

    sign_cls_e xc, yc;

    function automatic sign_cls_e classify(input logic signed [W-1:0] lo,
                                           input logic signed [W-1:0] hi);
        if (!lo[W-1])     return SC_NONNEG;
        else if (hi[W-1]) return SC_NEG;
        else              return SC_STRAD;
    endfunction

    always_comb begin
        xc = classify(xl, xu);
        yc = classify(yl, yu);
    end

    always_comb begin
        pick = '0;
        unique case ({xc, yc})
            {SC_NONNEG, SC_NONNEG}: pick = '{lo_a_up:1'b0, lo_b_up:1'b0, hi_a_up:1'b1, hi_b_up:1'b1, strad2:1'b0};
            {SC_NONNEG, SC_NEG}:    pick = '{lo_a_up:1'b1, lo_b_up:1'b0, hi_a_up:1'b0, hi_b_up:1'b1, strad2:1'b0};
            {SC_NONNEG, SC_STRAD}:  pick = '{lo_a_up:1'b1, lo_b_up:1'b0, hi_a_up:1'b1, hi_b_up:1'b1, strad2:1'b0};
            {SC_NEG,    SC_NONNEG}: pick = '{lo_a_up:1'b0, lo_b_up:1'b1, hi_a_up:1'b1, hi_b_up:1'b0, strad2:1'b0};
            {SC_NEG,    SC_NEG}:    pick = '{lo_a_up:1'b1, lo_b_up:1'b1, hi_a_up:1'b0, hi_b_up:1'b0, strad2:1'b0};
            {SC_NEG,    SC_STRAD}:  pick = '{lo_a_up:1'b0, lo_b_up:1'b1, hi_a_up:1'b0, hi_b_up:1'b0, strad2:1'b0};
            {SC_STRAD,  SC_NONNEG}: pick = '{lo_a_up:1'b0, lo_b_up:1'b1, hi_a_up:1'b1, hi_b_up:1'b1, strad2:1'b0};
            {SC_STRAD,  SC_NEG}:    pick = '{lo_a_up:1'b1, lo_b_up:1'b0, hi_a_up:1'b0, hi_b_up:1'b0, strad2:1'b0};
            {SC_STRAD,  SC_STRAD}:  pick = '{lo_a_up:1'b0, lo_b_up:1'b1, hi_a_up:1'b0, hi_b_up:1'b0, strad2:1'b1};
            default:                pick = '0;
        endcase
    end

    // Gap on either side means no common point.
    always_comb disjoint = (yu < xl) || (xu < yl);

endmodule

// File: rtl/ival_lane.sv
module ival_lane
    import ival_pkg::*;
#(
    parameter int W     = 16,
    parameter bit UPPER = 1'b0
) (
    input  logic [3:0]              cmd,
    input  logic signed [W-1:0]     xl,
    input  logic signed [W-1:0]     xu,
    input  logic signed [W-1:0]     yl,
    input  logic signed [W-1:0]     yu,
    input  logic                    a_up,
    input  logic                    b_up,
    input  logic                    use_alt,
    output logic signed [2*W-1:0]   res,
    output logic                    ovf
);

    localparam int RW  = 2 * W;
    localparam int SHW = $clog2(W);

    logic signed [RW-1:0] exl, exu, eyl, eyu;
    logic signed [RW-1:0] own_x, own_y;
    logic signed [RW-1:0] r_sum, r_diff, r_ctr, r_span;
    logic signed [RW-1:0] r_hull, r_ovlp, r_lenv, r_uenv;
    logic signed [RW-1:0] r_band, r_bor, r_bxor;
    logic signed [RW-1:0] p_main, p_alt, r_mul;
    logic signed [RW-1:0] r_shr, r_lsb;
    logic signed [W-1:0]  ma, mb, alt_y;
    logic signed [W-1:0]  bw_and, bw_or, bw_xor;
    logic [SHW-1:0]       k;

    function automatic logic signed [RW-1:0] smin(input logic signed [RW-1:0] a,
                                                  input logic signed [RW-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic signed [RW-1:0] smax(input logic signed [RW-1:0] a,
                                                  input logic signed [RW-1:0] b);
        return (a > b) ? a : b;
    endfunction

    // Redundant sign bit count, scanned from just below the MSB.
    function automatic logic signed [RW-1:0] sign_run(input logic [W-1:0] v);
        logic signed [RW-1:0] n;
        logic                 run;
        n   = '0;
        run = 1'b1;
        for (int i = W - 2; i >= 0; i--) begin
            if (run && (v[i] == v[W-1])) n = n + 1;
            else                         run = 1'b0;
        end
        return n;
    endfunction

    always_comb begin
        exl = {{W{xl[W-1]}}, xl};
        exu = {{W{xu[W-1]}}, xu};
        eyl = {{W{yl[W-1]}}, yl};
        eyu = {{W{yu[W-1]}}, yu};
        k   = yl[SHW-1:0];
    end

    // Lane-dependent selections: each lane works on its own endpoint pair,
    // and takes the outward direction for division rounding and products.
    generate
        if (UPPER) begin : g_up
            always_comb begin
                own_x  = exu;
                own_y  = eyu;
                r_diff = exu - eyl;
                r_hull = smax(exu, eyu);
                r_ovlp = smin(exu, eyu);
                alt_y  = yu;
                r_shr  = -((-exu) >>> k);
                r_lsb  = sign_run(xu);
                bw_and = xu & yu;
                bw_or  = xu | yu;
                bw_xor = xu ^ yu;
            end
        end else begin : g_lo
            always_comb begin
                own_x  = exl;
                own_y  = eyl;
                r_diff = exl - eyu;
                r_hull = smin(exl, eyl);
                r_ovlp = smax(exl, eyl);
                alt_y  = yl;
                r_shr  = exl >>> k;
                r_lsb  = sign_run(xl);
                bw_and = xl & yl;
                bw_or  = xl | yl;
                bw_xor = xl ^ yl;
            end
        end
    endgenerate

    always_comb begin
        r_sum  = own_x + own_y;
        r_ctr  = (exl + exu) >>> 1;
        r_span = exu - exl;
        r_lenv = smin(own_x, own_y);
        r_uenv = smax(own_x, own_y);
        r_band = {{W{bw_and[W-1]}}, bw_and};
        r_bor  = {{W{bw_or[W-1]}},  bw_or};
        r_bxor = {{W{bw_xor[W-1]}}, bw_xor};
    end

    // Product: primary operands chosen by the sign classifier; in the
    // straddle-by-straddle case a second fixed candidate is compared.
    always_comb begin
        ma     = a_up ? xu : xl;
        mb     = b_up ? yu : yl;
        p_main = ma * mb;
        p_alt  = xu * alt_y;
        if (use_alt) r_mul = UPPER ? smax(p_main, p_alt) : smin(p_main, p_alt);
        else         r_mul = p_main;
    end

    always_comb begin
        unique case (cmd)
            OP_SUM:  res = r_sum;
            OP_DIFF: res = r_diff;
            OP_CTR:  res = r_ctr;
            OP_SPAN: res = r_span;
            OP_HULL: res = r_hull;
            OP_OVLP: res = r_ovlp;
            OP_LENV: res = r_lenv;
            OP_UENV: res = r_uenv;
            OP_BAND: res = r_band;
            OP_BOR:  res = r_bor;
            OP_BXOR: res = r_bxor;
            OP_MUL:  res = r_mul;
            OP_SHR:  res = r_shr;
            OP_LSB:  res = r_lsb;
            default: res = '0;
        endcase
    end

    // Out of the operand format when the top bits disagree.
    always_comb ovf = (|res[RW-1:W-1]) && !(&res[RW-1:W-1]);

endmodule

// File: rtl/ival_alu.sv
module ival_alu
    import ival_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [3:0]             cmd,
    input  logic signed [W-1:0]    xl,
    input  logic signed [W-1:0]    xu,
    input  logic signed [W-1:0]    yl,
    input  logic signed [W-1:0]    yu,
    output logic                   out_valid,
    output logic signed [2*W-1:0]  zl,
    output logic signed [2*W-1:0]  zu,
    output logic                   ovf_lo,
    output logic                   ovf_hi,
    output logic                   disjoint
);

    localparam int RW = 2 * W;

    typedef struct packed {
        logic                 vld;
        logic signed [RW-1:0] lo;
        logic signed [RW-1:0] hi;
        logic                 ovl;
        logic                 ovh;
        logic                 dis;
    } res_st_t;

    mul_pick_t            pick;
    logic                 dis_c;
    logic signed [RW-1:0] lo_c, hi_c;
    logic                 ovl_c, ovh_c;
    res_st_t              st_d, st_q;

    ival_flag_gen #(.W(W)) u_flags (
        .xl       (xl),
        .xu       (xu),
        .yl       (yl),
        .yu       (yu),
        .pick     (pick),
        .disjoint (dis_c)
    );

    ival_lane #(.W(W), .UPPER(1'b0)) u_lane_lo (
        .cmd     (cmd),
        .xl      (xl),
        .xu      (xu),
        .yl      (yl),
        .yu      (yu),
        .a_up    (pick.lo_a_up),
        .b_up    (pick.lo_b_up),
        .use_alt (pick.strad2),
        .res     (lo_c),
        .ovf     (ovl_c)
    );

    ival_lane #(.W(W), .UPPER(1'b1)) u_lane_hi (
        .cmd     (cmd),
        .xl      (xl),
        .xu      (xu),
        .yl      (yl),
        .yu      (yu),
        .a_up    (pick.hi_a_up),
        .b_up    (pick.hi_b_up),
        .use_alt (pick.strad2),
        .res     (hi_c),
        .ovf     (ovh_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.lo  = lo_c;
            st_d.hi  = hi_c;
            st_d.ovl = ovl_c;
            st_d.ovh = ovh_c;
            st_d.dis = dis_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign zl        = st_q.lo;
    assign zu        = st_q.hi;
    assign ovf_lo    = st_q.ovl;
    assign ovf_hi    = st_q.ovh;
    assign disjoint  = st_q.dis;

endmodule

// File: rtl/ival_alu_chk.sv
module ival_alu_chk #(
    parameter int W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [3:0]             cmd,
    input logic signed [W-1:0]    xl,
    input logic signed [W-1:0]    xu,
    input logic signed [W-1:0]    yl,
    input logic signed [W-1:0]    yu,
    input logic                   out_valid,
    input logic signed [2*W-1:0]  zl,
    input logic signed [2*W-1:0]  zu,
    input logic                   ovf_lo,
    input logic                   ovf_hi,
    input logic                   disjoint
);

    localparam logic signed [2*W-1:0] FMAX = (2*W)'((64'sd1 <<< (W-1)) - 1);
    localparam logic signed [2*W-1:0] FMIN = -FMAX - 1;

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(zl) && $stable(zu) && $stable(disjoint)));

    p_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cmd == 4'd0) |=> (zl == $past(xl) + $past(yl)));

    p_disjoint_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (disjoint == (($past(yu) < $past(xl)) || ($past(xu) < $past(yl)))));

    p_overlap_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cmd == 4'd5 && xl <= xu && yl <= yu) |=> (disjoint || zl <= zu));

    p_mul_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cmd == 4'd11 && xl <= xu && yl <= yu) |=> (zl <= zu));

    p_ovf_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ovf_lo == (zl > FMAX || zl < FMIN)));

    p_ovf_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ovf_hi == (zu > FMAX || zu < FMIN)));

endmodule

bind ival_alu ival_alu_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .cmd       (cmd),
    .xl        (xl),
    .xu        (xu),
    .yl        (yl),
    .yu        (yu),
    .out_valid (out_valid),
    .zl        (zl),
    .zu        (zu),
    .ovf_lo    (ovf_lo),
    .ovf_hi    (ovf_hi),
    .disjoint  (disjoint)
);

// File: tb/sim_ival_alu.sv
`timescale 1ns/1ps
module sim_ival_alu;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [3:0]         cmd = '0;
    logic signed [15:0] xl = '0, xu = '0, yl = '0, yu = '0;
    logic               out_valid;
    logic signed [31:0] zl, zu;
    logic               ovf_lo, ovf_hi, disjoint;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ival_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cmd(cmd),
        .xl(xl), .xu(xu), .yl(yl), .yu(yu),
        .out_valid(out_valid), .zl(zl), .zu(zu),
        .ovf_lo(ovf_lo), .ovf_hi(ovf_hi), .disjoint(disjoint)
    );

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic longint fdiv(input longint a, input longint d);
        return (a >= 0) ? a / d : -((-a + d - 1) / d);
    endfunction

    function automatic longint cdiv(input longint a, input longint d);
        return (a >= 0) ? (a + d - 1) / d : -((-a) / d);
    endfunction

    function automatic longint lmin(input longint a, input longint b);
        return (a < b) ? a : b;
    endfunction

    function automatic longint lmax(input longint a, input longint b);
        return (a > b) ? a : b;
    endfunction

    function automatic longint sbits(input logic [15:0] v);
        longint n = 0;
        for (int i = 14; i >= 0; i--) begin
            if (v[i] != v[15]) break;
            n++;
        end
        return n;
    endfunction

    // Expected endpoints straight from the requirement text.
    task automatic model(input logic [3:0] c,
                         input logic signed [15:0] a, input logic signed [15:0] b,
                         input logic signed [15:0] p, input logic signed [15:0] q,
                         output longint lo, output longint hi);
        longint al = a, au = b, bl = p, bu = q;
        logic signed [15:0] t1, t2;
        longint m1, m2, m3, m4, d;
        lo = 0; hi = 0;
        case (c)
            4'd0:  begin lo = al + bl; hi = au + bu; end
            4'd1:  begin lo = al - bu; hi = au - bl; end
            4'd2:  begin lo = fdiv(al + au, 2); hi = lo; end
            4'd3:  begin lo = au - al; hi = lo; end
            4'd4:  begin lo = lmin(al, bl); hi = lmax(au, bu); end
            4'd5:  begin lo = lmax(al, bl); hi = lmin(au, bu); end
            4'd6:  begin lo = lmin(al, bl); hi = lmin(au, bu); end
            4'd7:  begin lo = lmax(al, bl); hi = lmax(au, bu); end
            4'd8:  begin t1 = a & p; t2 = b & q; lo = t1; hi = t2; end
            4'd9:  begin t1 = a | p; t2 = b | q; lo = t1; hi = t2; end
            4'd10: begin t1 = a ^ p; t2 = b ^ q; lo = t1; hi = t2; end
            4'd11: begin
                m1 = al * bl; m2 = al * bu; m3 = au * bl; m4 = au * bu;
                lo = lmin(lmin(m1, m2), lmin(m3, m4));
                hi = lmax(lmax(m1, m2), lmax(m3, m4));
            end
            4'd12: begin d = 64'd1 << (bl & 15); lo = fdiv(al, d); hi = cdiv(au, d); end
            4'd13: begin lo = sbits(a); hi = sbits(b); end
            default: begin lo = 0; hi = 0; end
        endcase
    endtask

    function automatic bit outside(input longint v);
        return (v > 32767) || (v < -32768);
    endfunction

    // Issue one command and compare every output one cycle later.
    task automatic run_op(input string tag, input logic [3:0] c,
                          input logic signed [15:0] a, input logic signed [15:0] b,
                          input logic signed [15:0] p, input logic signed [15:0] q);
        longint elo, ehi;
        model(c, a, b, p, q, elo, ehi);
        @(negedge clk);
        in_valid = 1'b1; cmd = c; xl = a; xu = b; yl = p; yu = q;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, "out_valid", out_valid, 1);
        check(tag, "zl", zl, elo);
        check(tag, "zu", zu, ehi);
        check("R10", "ovf_lo", ovf_lo, outside(elo));
        check("R10", "ovf_hi", ovf_hi, outside(ehi));
        check("R4", "disjoint", disjoint,
              ((longint'(q) < longint'(a)) || (longint'(b) < longint'(p))) ? 1 : 0);
    endtask

    task automatic t_reset_r1;
        check("R1", "reset out_valid", out_valid, 0);
        check("R1", "reset zl", zl, 0);
        check("R1", "reset zu", zu, 0);
        check("R1", "reset flags", {ovf_lo, ovf_hi, disjoint}, 0);
    endtask

    task automatic t_hold_r1;
        longint kl, ku;
        run_op("R1", 4'd0, 16'sd10, 16'sd20, 16'sd1, 16'sd2);
        kl = zl; ku = zu;
        @(negedge clk);
        xl = 16'sd999; yl = -16'sd5; cmd = 4'd3;
        @(negedge clk);
        check("R1", "idle out_valid", out_valid, 0);
        check("R1", "idle zl held", zl, kl);
        check("R1", "idle zu held", zu, ku);
    endtask

    task automatic t_sumdiff_r2;
        run_op("R2", 4'd0, 16'sd1, 16'sd2, 16'sd3, 16'sd4);
        run_op("R2", 4'd0, -16'sd50, 16'sd7, -16'sd3, 16'sd90);
        run_op("R2", 4'd1, 16'sd1, 16'sd2, 16'sd3, 16'sd4);
        run_op("R2", 4'd1, -16'sd100, -16'sd10, 16'sd20, 16'sd300);
    endtask

    task automatic t_ctrspan_r3;
        run_op("R3", 4'd2, 16'sd3, 16'sd8, 16'sd0, 16'sd0);
        run_op("R3", 4'd2, -16'sd9, 16'sd2, 16'sd0, 16'sd0);
        run_op("R3", 4'd3, -16'sd32768, 16'sd32767, 16'sd0, 16'sd0);
        run_op("R3", 4'd3, 16'sd5, 16'sd5, 16'sd0, 16'sd0);
    endtask

    task automatic t_hull_overlap_r4;
        run_op("R4", 4'd4, 16'sd1, 16'sd5, 16'sd3, 16'sd9);
        run_op("R4", 4'd4, -16'sd20, -16'sd10, 16'sd10, 16'sd20);
        run_op("R4", 4'd5, 16'sd1, 16'sd5, 16'sd3, 16'sd9);
        run_op("R4", 4'd5, 16'sd0, 16'sd10, 16'sd2, 16'sd4);
        run_op("R4", 4'd5, 16'sd1, 16'sd5, 16'sd5, 16'sd9);
        run_op("R4", 4'd5, 16'sd1, 16'sd4, 16'sd5, 16'sd9);
        run_op("R4", 4'd5, 16'sd10, 16'sd20, -16'sd5, 16'sd9);
    endtask

    task automatic t_env_r5;
        run_op("R5", 4'd6, -16'sd4, 16'sd30, 16'sd2, 16'sd6);
        run_op("R5", 4'd7, -16'sd4, 16'sd30, 16'sd2, 16'sd6);
    endtask

    task automatic t_bitwise_r6;
        run_op("R6", 4'd8, -16'sd1, 16'sh1234, 16'sh00F0, -16'sd256);
        run_op("R6", 4'd9, 16'sh0F00, 16'sh0001, -16'sd32768, 16'sh0002);
        run_op("R6", 4'd10, 16'sh5555, -16'sd1, 16'sh7FFF, 16'sh00FF);
    endtask

    task automatic t_mul_r7;
        run_op("R7", 4'd11, 16'sd2, 16'sd3, 16'sd4, 16'sd5);
        run_op("R7", 4'd11, 16'sd2, 16'sd3, -16'sd5, -16'sd4);
        run_op("R7", 4'd11, 16'sd2, 16'sd3, -16'sd5, 16'sd4);
        run_op("R7", 4'd11, -16'sd3, -16'sd2, 16'sd4, 16'sd5);
        run_op("R7", 4'd11, -16'sd3, -16'sd2, -16'sd5, -16'sd4);
        run_op("R7", 4'd11, -16'sd3, -16'sd2, -16'sd5, 16'sd4);
        run_op("R7", 4'd11, -16'sd3, 16'sd2, 16'sd4, 16'sd5);
        run_op("R7", 4'd11, -16'sd3, 16'sd2, -16'sd5, -16'sd4);
        run_op("R7", 4'd11, -16'sd3, 16'sd5, -16'sd7, 16'sd2);
        run_op("R7", 4'd11, -16'sd9, 16'sd2, -16'sd1, 16'sd8);
        run_op("R7", 4'd11, 16'sd200, 16'sd300, 16'sd200, 16'sd300);
        run_op("R7", 4'd11, -16'sd32768, 16'sd32767, -16'sd32768, 16'sd32767);
    endtask

    task automatic t_shr_r8;
        run_op("R8", 4'd12, 16'sd7, 16'sd7, 16'sd1, 16'sd1);
        run_op("R8", 4'd12, -16'sd7, -16'sd7, 16'sd2, 16'sd2);
        run_op("R8", 4'd12, -16'sd32768, 16'sd32767, 16'sd15, 16'sd15);
        run_op("R8", 4'd12, 16'sd64, 16'sd64, 16'sd0, 16'sd0);
        run_op("R8", 4'd12, -16'sd100, 16'sd100, 16'sh0013, 16'sd0);
    endtask

    task automatic t_signbits_r9;
        run_op("R9", 4'd13, 16'sd0, -16'sd1, 16'sd0, 16'sd0);
        run_op("R9", 4'd13, 16'sh4000, 16'sd1, 16'sd0, 16'sd0);
        run_op("R9", 4'd13, -16'sd32768, 16'sh00C0, 16'sd0, 16'sd0);
    endtask

    task automatic t_ovf_r10;
        run_op("R10", 4'd0, 16'sd0, 16'sd32767, 16'sd0, 16'sd1);
        run_op("R10", 4'd0, -16'sd32768, 16'sd0, -16'sd1, 16'sd0);
        run_op("R10", 4'd1, -16'sd32768, 16'sd32767, -16'sd1, 16'sd1);
    endtask

    task automatic t_reserved_r11;
        run_op("R11", 4'd14, 16'sd100, 16'sd200, 16'sd3, 16'sd4);
        run_op("R11", 4'd15, -16'sd32768, 16'sd32767, 16'sd5, 16'sd6);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_r1();
        rst_n = 1'b1;
        @(negedge clk);
        t_sumdiff_r2();
        t_ctrspan_r3();
        t_hull_overlap_r4();
        t_env_r5();
        t_bitwise_r6();
        t_mul_r7();
        t_shr_r8();
        t_signbits_r9();
        t_ovf_r10();
        t_reserved_r11();
        t_hold_r1();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule